// File: doc/BRIEF.md
# Thirty-Two Line GPIO Controller with Per-Line Interrupt Wires

This block is a register-mapped controller for 32 general-purpose pads. Software picks each pad's direction and output level. It reads the pad levels back after they pass through a synchroniser. It also chooses how each of the lower sixteen pads signals an interrupt. Each of those sixteen pads has its own active-high interrupt wire to the parent interrupt controller. Masking is done in the parent controller, not here.

The output data bit has two uses. It drives the pad when the pad is an output, and it also selects the interrupt polarity: 0 means rising edge or high level, and 1 means falling edge or low level. A mode bit turns on detection of both edges. A trigger-kind bit selects edge (single-cycle pulse) or level (the output follows the qualified input). A low-level or falling condition is inverted inside the block, so every interrupt wire is active high.

The bus is a simple single-cycle slave. A request is sampled on a rising clock edge while `bus_sel` is high. Writes take effect at that edge. Read data appears on `bus_rdata` after that same edge and stays valid for one cycle. It returns to 0 when no read is pending. Offsets (byte addresses, all registers 32 bits): direction 0x00, input data 0x08 (read only), output data 0x10, output set 0x18 (write only), output clear 0x20 (write only), both-edge mode 0x30, trigger kind 0x38.

Top module: `gpio_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, `pad_oe`, `pad_out`, `irq` and `bus_rdata` are 0, and every line is an input set to rising edge, single-edge.
- R2: Registers at 0x00, 0x10, 0x30 and 0x38 read back the last value written. A read of 0x18, 0x20 or any undefined offset returns 0. A write to 0x08 changes nothing.
- R3: Writing 0x18 sets the output data bits where the written word has a 1. Writing 0x20 clears them. Bits written as 0 keep their value.
- R4: `pad_oe` equals the direction register (1 = drive) and `pad_out` equals the output data register.
- R5: The input data register shows `pad_in` after a two-flop synchroniser. If a pad changes before clock edge k, a read sampled at edge k+1 still returns the old value, and a read sampled at edge k+2 returns the new value.
- R6: For a line with mode 0 and kind 0, output data 0 gives a one-cycle pulse on a rising pad edge, and output data 1 gives a one-cycle pulse on a falling pad edge. The pulse is high between edges k+2 and k+3 for a pad change before edge k.
- R7: When the mode bit of a line is 1, that line pulses on both edges, whatever its output data and kind bits are.
- R8: When kind is 1 and mode is 0, the line's `irq` follows the synchronised pad (output data 0) or its inverse (output data 1), with the same two-edge delay as R6.
- R9: Pads 16 to 31 never change any `irq` bit, and each pad 0 to 15 drives only its own `irq` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the request |
| pad_in | input | 32 | Raw pad levels (asynchronous) |
| pad_out | output | 32 | Pad drive levels |
| pad_oe | output | 32 | Pad drive enables |
| irq | output | 16 | Per-line active-high interrupts |

## Verification
A wrong synchroniser depth or detector state shows up as an `irq` pulse one cycle early or late, or as a pulse that lasts two cycles. The bench samples both the cycle where the pulse is due and the cycle after it, so a timing error is seen within one cycle. A wrong polarity or mode decode asserts a bit of `irq` at the wrong pad transition. A crossed line asserts a neighbouring bit. Both are caught at the first toggle of the affected line. Register decode faults appear on the next read-back, and on `pad_out` or `pad_oe` right after the write edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_IN   = 8'h08;
  localparam logic [7:0] OFS_OUT  = 8'h10;
  localparam logic [7:0] OFS_SET  = 8'h18;
  localparam logic [7:0] OFS_CLR  = 8'h20;
  localparam logic [7:0] OFS_BOTH = 8'h30;
  localparam logic [7:0] OFS_KIND = 8'h38;

  typedef enum logic [2:0] {
    TRIG_RISE,
    TRIG_FALL,
    TRIG_ANY,
    TRIG_HIGH,
    TRIG_LOW
  } trig_e;

  function automatic trig_e pick_trig(input logic pol, input logic both, input logic lvl);
    if (both)     return TRIG_ANY;
    else if (lvl) return pol ? TRIG_LOW : TRIG_HIGH;
    else          return pol ? TRIG_FALL : TRIG_RISE;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] rdata,
  input  logic [NLINES-1:0] sync_in,
  output logic [NLINES-1:0] dir_q,
  output logic [NLINES-1:0] out_q,
  output logic [NLINES-1:0] both_q,
  output logic [NLINES-1:0] kind_q
);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_IN   = AW'(OFS_IN);
  localparam logic [AW-1:0] A_OUT  = AW'(OFS_OUT);
  localparam logic [AW-1:0] A_SET  = AW'(OFS_SET);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_BOTH = AW'(OFS_BOTH);
  localparam logic [AW-1:0] A_KIND = AW'(OFS_KIND);

  logic              wen, ren;
  logic [NLINES-1:0] set_mask, clr_mask, out_nxt, rd_mux;

  assign wen = sel && wr;
  assign ren = sel && !wr;

  always_comb begin
    set_mask = (wen && addr == A_SET) ? wdata : '0;
    clr_mask = (wen && addr == A_CLR) ? wdata : '0;
    if (wen && addr == A_OUT) out_nxt = wdata;
    else                      out_nxt = (out_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      both_q <= '0;
      kind_q <= '0;
    end else begin
      out_q <= out_nxt;
      if (wen && addr == A_DIR)  dir_q  <= wdata;
      if (wen && addr == A_BOTH) both_q <= wdata;
      if (wen && addr == A_KIND) kind_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rd_mux = dir_q;
      A_IN:    rd_mux = sync_in;
      A_OUT:   rd_mux = out_q;
      A_BOTH:  rd_mux = both_q;
      A_KIND:  rd_mux = kind_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= rd_mux;
    else          rdata <= '0;
  end
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det
  import gpio_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] din,
  input  logic [NIRQ-1:0] pol,
  input  logic [NIRQ-1:0] both,
  input  logic [NIRQ-1:0] lvl,
  output logic [NIRQ-1:0] irq
);
  logic [NIRQ-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= din;
  end

  genvar i;
  generate
    for (i = 0; i < NIRQ; i++) begin : g_line
      trig_e trig;
      logic  hit;

      always_comb begin
        trig = pick_trig(pol[i], both[i], lvl[i]);
        case (trig)
          TRIG_RISE: hit = din[i] & ~prev[i];
          TRIG_FALL: hit = ~din[i] & prev[i];
          TRIG_ANY:  hit = din[i] ^ prev[i];
          TRIG_HIGH: hit = din[i];
          TRIG_LOW:  hit = ~din[i];
          default:   hit = 1'b0;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) irq[i] <= 1'b0;
        else     irq[i] <= hit;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NLINES      = 32,
  parameter int NIRQ        = 16,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NIRQ-1:0]   irq
);
  logic [NLINES-1:0] sync_q, dir_q, out_q, both_q, kind_q;

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_q)
  );

  gpio_regs #(.NLINES(NLINES), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .sync_in (sync_q),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .both_q  (both_q),
    .kind_q  (kind_q)
  );

  gpio_irq_det #(.NIRQ(NIRQ)) u_det (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_q[NIRQ-1:0]),
    .pol  (out_q[NIRQ-1:0]),
    .both (both_q[NIRQ-1:0]),
    .lvl  (kind_q[NIRQ-1:0]),
    .irq  (irq)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NLINES = 32,
  parameter int NIRQ   = 16,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] bus_rdata,
  input logic [NLINES-1:0] pad_out,
  input logic [NLINES-1:0] pad_oe,
  input logic [NIRQ-1:0]   irq
);
  logic undef_rd;
  assign undef_rd = bus_sel && !bus_wr &&
                    !(bus_addr == AW'(8'h00) || bus_addr == AW'(8'h08) ||
                      bus_addr == AW'(8'h10) || bus_addr == AW'(8'h30) ||
                      bus_addr == AW'(8'h38));

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  // R2
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    undef_rd |=> bus_rdata == '0);

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == AW'(8'h18)) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == AW'(8'h20)) |=> ((pad_out & $past(bus_wdata)) == '0));

  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_sel && bus_wr)) |-> $stable(pad_oe));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NLINES(NLINES), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [15:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // mode: 0 rise, 1 fall, 2 both, 3 high level, 4 low level
  function automatic logic [15:0] model(input int mode, input logic [31:0] o, input logic [31:0] n);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      case (mode)
        0: r[b] = n[b] & ~o[b];
        1: r[b] = ~n[b] & o[b];
        2: r[b] = n[b] ^ o[b];
        3: r[b] = n[b];
        default: r[b] = ~n[b];
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(input int mode);
    case (mode)
      0, 1: return "R6";
      2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] oldp, newp;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {16'h0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    rd(8'h00, d); chk("R1 dir", d, 32'h0);
    rd(8'h10, d); chk("R1 out", d, 32'h0);
    rd(8'h30, d); chk("R1 both", d, 32'h0);
    rd(8'h38, d); chk("R1 kind", d, 32'h0);

    // R2 readback and holes
    wr(8'h00, 32'h1234_5678); rd(8'h00, d); chk("R2 dir", d, 32'h1234_5678);
    chk("R4 pad_oe", pad_oe, 32'h1234_5678);
    wr(8'h30, 32'hDEAD_BEEF); rd(8'h30, d); chk("R2 both", d, 32'hDEAD_BEEF);
    wr(8'h38, 32'h0F0F_A5A5); rd(8'h38, d); chk("R2 kind", d, 32'h0F0F_A5A5);
    wr(8'h10, 32'hCAFE_0001); rd(8'h10, d); chk("R2 out", d, 32'hCAFE_0001);
    chk("R4 pad_out", pad_out, 32'hCAFE_0001);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R2 input ro", d, 32'h0);
    rd(8'h18, d); chk("R2 set reads 0", d, 32'h0);
    rd(8'h20, d); chk("R2 clr reads 0", d, 32'h0);
    rd(8'h40, d); chk("R2 undef", d, 32'h0);
    rd(8'h04, d); chk("R2 undef4", d, 32'h0);

    // R3 set/clear
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h0000_00F0); rd(8'h10, d); chk("R3 set", d, 32'h0000_00F0);
    wr(8'h18, 32'h8000_000F); rd(8'h10, d); chk("R3 set2", d, 32'h8000_00FF);
    wr(8'h20, 32'h8000_0030); rd(8'h10, d); chk("R3 clr", d, 32'h0000_00CF);
    chk("R4 pad_out after clr", pad_out, 32'h0000_00CF);
    wr(8'h00, 32'h0); chk("R4 pad_oe cleared", pad_oe, 32'h0);

    // R5 synchroniser latency
    pad_in = 32'h5A5A_0F0F;
    @(posedge clk);
    @(negedge clk);
    rd(8'h08, d); chk("R5 old at k+1", d, 32'h0);
    rd(8'h08, d); chk("R5 new at k+2", d, 32'h5A5A_0F0F);
    pad_in = 32'h0;
    repeat (4) @(negedge clk);

    // R6-R9 sweep of every mode over every interrupt line
    for (int mode = 0; mode < 5; mode++) begin
      case (mode)
        0: begin wr(8'h10, 32'h0);         wr(8'h30, 32'h0);         wr(8'h38, 32'h0); end
        1: begin wr(8'h10, 32'hFFFF_FFFF); wr(8'h30, 32'h0);         wr(8'h38, 32'h0); end
        2: begin wr(8'h10, 32'hA5A5_A5A5); wr(8'h30, 32'hFFFF_FFFF); wr(8'h38, 32'h0F0F_0F0F); end
        3: begin wr(8'h10, 32'h0);         wr(8'h30, 32'h0);         wr(8'h38, 32'hFFFF_FFFF); end
        default: begin wr(8'h10, 32'hFFFF_FFFF); wr(8'h30, 32'h0);   wr(8'h38, 32'hFFFF_FFFF); end
      endcase
      repeat (4) @(negedge clk);
      oldp = pad_in;
      chk({req_of(mode), " settled"}, {16'h0, irq}, {16'h0, model(mode, oldp, oldp)});
      for (int pass = 0; pass < 2; pass++) begin
        for (int j = 0; j < 18; j++) begin
          int line;
          line = (j < 16) ? j : ((j == 16) ? 20 : 31);
          newp = oldp ^ (32'h1 << line);
          pad_in = newp;
          repeat (3) @(posedge clk);
          @(negedge clk);
          chk((line > 15) ? "R9 upper line" : {req_of(mode), "/R9 line"},
              {16'h0, irq}, {16'h0, model(mode, oldp, newp)});
          @(posedge clk);
          @(negedge clk);
          chk({req_of(mode), " after"}, {16'h0, irq}, {16'h0, model(mode, newp, newp)});
          oldp = newp;
        end
      end
      rd(8'h08, d); chk("R5 idata sweep", d, oldp);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule